// File: doc/BRIEF.md
# Strobe-Free Addressable Output Expander

This block turns a stream of 8-bit host words into 128 individually held output bits. The host port has no write strobe: it only presents a byte and holds it. Each byte carries three fields: a device number that picks one of sixteen 8-bit output groups, a bit position inside that group, and the value to store there.

A write is inferred when the device field changes to a new value and stays there. The block synchronizes the byte and waits until the device field has been steady. It then captures the bit position and the value, waits a programmable settling interval, and drives an active-low enable pulse of programmable width to the chosen group. That group stores the value at the captured position.

To write to the same group twice, the host must place a byte for a different group in between. Outputs that need no change can simply be rewritten with the value they already hold.

Top module: `bytewise_out_expander`

## Requirements
- R1: Host byte bits [3:0] give the device number, bits [6:4] the bit position and bit 7 the value. A write stores the value on output bit `device*8 + position` and changes no other output bit.
- R2: Every group enable is active low and idles high. At most one enable is low at a time, and only the enable of the captured device goes low.
- R3: Outputs hold their values while every enable is high. A change of bit position or value with an unchanged device number changes no output.
- R4: A new selection starts a write. A new selection is a synchronized device number that matches its value of the previous cycle and differs from the last accepted device number. The write is a settling interval of TD_CYC cycles with all enables high, followed by PW_CYC cycles with the selected enable low.
- R5: Presenting the same device number again produces no write. Busy stays low and the outputs are unchanged.
- R6: Rewriting an output with the value it already holds leaves all outputs unchanged.
- R7: A device number that is present on the synchronized input for a single cycle only is not accepted as a selection.
- R8: The bit position and value are captured when the write starts and stay fixed until its pulse ends. Input changes during a write do not alter it. A different device number still present once the block is idle starts the next write.
- R9: Reset clears all 128 outputs to 0, drives every enable high, clears busy and sets the last accepted device number to 0.
- R10: Busy is high for exactly TD_CYC + PW_CYC consecutive cycles per write, starting the cycle after a selection is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_byte | input | 8 | Host word with device, position and value fields, asynchronous to clk |
| out_bits | output | 128 | Held output bits, group d at bits [8d+7:8d] |
| busy | output | 1 | High during the settling and pulse phases of a write |

## Verification
A wrong captured position or value, or a wrong enable, shows up as a wrong or extra bit in `out_bits`. This is visible in the cycle after the first pulse cycle, and so by the time busy falls. A wrong last-accepted device number or a faulty steadiness test shows up as a spurious or missing busy interval a few cycles after the byte changes. A counter that is off by one changes the busy length of every write.

// File: rtl/sfx_pkg.sv
package sfx_pkg;
  localparam int BYTE_W = 8;
  localparam int DEV_W  = 4;
  localparam int IDX_W  = 3;
  localparam int N_DEV  = 1 << DEV_W;
  localparam int N_BITS = 1 << IDX_W;
  localparam int N_OUT  = N_DEV * N_BITS;

  typedef enum logic [1:0] {ST_IDLE, ST_SETTLE, ST_STROBE} seq_state_e;

  function automatic logic [DEV_W-1:0] f_dev(input logic [BYTE_W-1:0] b);
    return b[DEV_W-1:0];
  endfunction

  function automatic logic [IDX_W-1:0] f_idx(input logic [BYTE_W-1:0] b);
    return b[DEV_W+IDX_W-1:DEV_W];
  endfunction

  function automatic logic f_dat(input logic [BYTE_W-1:0] b);
    return b[BYTE_W-1];
  endfunction
endpackage

// File: rtl/sfx_sync.sv
module sfx_sync #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      q      <= '0;
    end else begin
      meta_q <= d;
      q      <= meta_q;
    end
  end
endmodule

// File: rtl/sfx_sel_track.sv
module sfx_sel_track
  import sfx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BYTE_W-1:0] cur_byte,
  input  logic              idle,
  output logic              new_sel
);
  logic [BYTE_W-1:0] prev_q;
  logic [DEV_W-1:0]  last_dev_q;
  logic              sel_steady;

  assign sel_steady = (f_dev(cur_byte) == f_dev(prev_q));
  assign new_sel    = idle && sel_steady && (f_dev(cur_byte) != last_dev_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q     <= '0;
      last_dev_q <= '0;
    end else begin
      prev_q <= cur_byte;
      if (new_sel) last_dev_q <= f_dev(cur_byte);
    end
  end
endmodule

// File: rtl/sfx_strobe_seq.sv
module sfx_strobe_seq
  import sfx_pkg::*;
#(
  parameter int TD_CYC = 3,
  parameter int PW_CYC = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              new_sel,
  input  logic [BYTE_W-1:0] cur_byte,
  output logic [N_DEV-1:0]  en_n,
  output logic [DEV_W-1:0]  cap_dev,
  output logic [IDX_W-1:0]  cap_idx,
  output logic              cap_dat,
  output logic              delay_on,
  output logic              pulse_on,
  output logic              busy
);
  localparam int MAXC  = (TD_CYC > PW_CYC) ? TD_CYC : PW_CYC;
  localparam int CNT_W = $clog2(MAXC + 1);

  seq_state_e       state_q;
  logic [CNT_W-1:0] cnt_q;

  assign delay_on = (state_q == ST_SETTLE);
  assign pulse_on = (state_q == ST_STROBE);
  assign busy     = delay_on || pulse_on;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      cap_dev <= '0;
      cap_idx <= '0;
      cap_dat <= 1'b0;
    end else begin
      case (state_q)
        ST_IDLE: if (new_sel) begin
          state_q <= ST_SETTLE;
          cnt_q   <= CNT_W'(TD_CYC - 1);
          cap_dev <= f_dev(cur_byte);
          cap_idx <= f_idx(cur_byte);
          cap_dat <= f_dat(cur_byte);
        end
        ST_SETTLE: if (cnt_q == '0) begin
          state_q <= ST_STROBE;
          cnt_q   <= CNT_W'(PW_CYC - 1);
        end else begin
          cnt_q <= cnt_q - 1'b1;
        end
        ST_STROBE: if (cnt_q == '0) begin
          state_q <= ST_IDLE;
        end else begin
          cnt_q <= cnt_q - 1'b1;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    en_n = '1;
    if (pulse_on) en_n[cap_dev] = 1'b0;
  end
endmodule

// File: rtl/sfx_latch_bank.sv
module sfx_latch_bank
  import sfx_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_DEV-1:0] en_n,
  input  logic [IDX_W-1:0] cap_idx,
  input  logic             cap_dat,
  output logic [N_OUT-1:0] out_bits
);
  for (genvar g = 0; g < N_DEV; g++) begin : g_grp
    logic [N_BITS-1:0] grp_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        grp_q <= '0;
      else if (!en_n[g]) grp_q[cap_idx] <= cap_dat;
    end
    assign out_bits[g*N_BITS +: N_BITS] = grp_q;
  end
endmodule

// File: rtl/bytewise_out_expander.sv
module bytewise_out_expander
  import sfx_pkg::*;
#(
  parameter int TD_CYC = 3,
  parameter int PW_CYC = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BYTE_W-1:0] host_byte,
  output logic [N_OUT-1:0]  out_bits,
  output logic              busy
);
  logic [BYTE_W-1:0] sync_byte;
  logic              new_sel;
  logic [N_DEV-1:0]  en_n;
  logic [DEV_W-1:0]  cap_dev;
  logic [IDX_W-1:0]  cap_idx;
  logic              cap_dat;
  logic              delay_on;
  logic              pulse_on;

  sfx_sync #(.W(BYTE_W)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(host_byte), .q(sync_byte)
  );

  sfx_sel_track u_track (
    .clk(clk), .rst_n(rst_n), .cur_byte(sync_byte), .idle(!busy), .new_sel(new_sel)
  );

  sfx_strobe_seq #(.TD_CYC(TD_CYC), .PW_CYC(PW_CYC)) u_seq (
    .clk(clk), .rst_n(rst_n), .new_sel(new_sel), .cur_byte(sync_byte),
    .en_n(en_n), .cap_dev(cap_dev), .cap_idx(cap_idx), .cap_dat(cap_dat),
    .delay_on(delay_on), .pulse_on(pulse_on), .busy(busy)
  );

  sfx_latch_bank u_bank (
    .clk(clk), .rst_n(rst_n), .en_n(en_n), .cap_idx(cap_idx),
    .cap_dat(cap_dat), .out_bits(out_bits)
  );
endmodule

// File: rtl/sfx_checker.sv
module sfx_checker
  import sfx_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic [N_DEV-1:0] en_n,
  input logic [N_OUT-1:0] out_bits,
  input logic             busy,
  input logic             delay_on,
  input logic             pulse_on,
  input logic             new_sel,
  input logic [IDX_W-1:0] cap_idx,
  input logic             cap_dat
);
  AST_ONE_ENABLE: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(~en_n)); // R2
  AST_IDLE_ENABLES_HIGH: assert property (@(posedge clk) disable iff (!rst_n) !busy |-> (&en_n)); // R2
  AST_HOLD_WHEN_DISABLED: assert property (@(posedge clk) disable iff (!rst_n) (&en_n) |=> $stable(out_bits)); // R3
  AST_PULSE_AFTER_SETTLE: assert property (@(posedge clk) disable iff (!rst_n) $rose(pulse_on) |-> $past(delay_on)); // R4
  AST_SEL_STARTS_WRITE: assert property (@(posedge clk) disable iff (!rst_n) new_sel |=> delay_on); // R4
  AST_CAPTURE_FIXED: assert property (@(posedge clk) disable iff (!rst_n) (busy && $past(busy)) |-> ($stable(cap_idx) && $stable(cap_dat))); // R8
  AST_BUSY_ENDS_PULSE: assert property (@(posedge clk) disable iff (!rst_n) $fell(busy) |-> $past(pulse_on)); // R10
endmodule

bind bytewise_out_expander sfx_checker u_chk (
  .clk(clk), .rst_n(rst_n), .en_n(en_n), .out_bits(out_bits), .busy(busy),
  .delay_on(delay_on), .pulse_on(pulse_on), .new_sel(new_sel),
  .cap_idx(cap_idx), .cap_dat(cap_dat)
);

// File: tb/test_bytewise_out_expander.sv
`timescale 1ns/1ps
module test_bytewise_out_expander;
  localparam int TD = 3;
  localparam int PW = 2;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [7:0]   host_byte = 8'h00;
  logic [127:0] out_bits;
  logic         busy;

  int n_chk = 0, n_bad = 0;
  int done_cnt = 0, rise_cnt = 0, blen = 0;
  logic busy_prev = 1'b0;
  logic [127:0] model = '0;
  logic [127:0] exp_q[$];
  bit finished = 0;

  always #2.5 clk = ~clk;

  bytewise_out_expander #(.TD_CYC(TD), .PW_CYC(PW)) i_bytewise_out_expander (
    .clk(clk), .rst_n(rst_n), .host_byte(host_byte), .out_bits(out_bits), .busy(busy)
  );

  task automatic check(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] mk(input int dev, input int idx, input bit dat);
    return {dat, 3'(idx), 4'(dev)};
  endfunction

  // driver: present a byte, push expected outputs into the scoreboard
  task automatic push_write(input int dev, input int idx, input bit dat);
    @(negedge clk);
    model[dev*8 + idx] = dat;
    exp_q.push_back(model);
    host_byte = mk(dev, idx, dat);
  endtask

  task automatic wait_done(input int target);
    while (done_cnt < target) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic wr(input int dev, input int idx, input bit dat);
    int t;
    t = done_cnt + 1;
    push_write(dev, idx, dat);
    wait_done(t);
  endtask

  task automatic quiet(input logic [7:0] b, input string req);
    int r0;
    r0 = rise_cnt;
    @(negedge clk);
    host_byte = b;
    repeat (15) @(negedge clk);
    check(rise_cnt == r0, req, 128'(rise_cnt), 128'(r0));
    check(out_bits == model, req, out_bits, model);
  endtask

  // monitor: pop and compare at the end of each write
  always @(negedge clk) begin
    if (rst_n) begin
      if (busy && !busy_prev) rise_cnt++;
      if (busy) blen++;
      if (busy_prev && !busy) begin
        check(blen == TD + PW, "R10 busy length", 128'(blen), 128'(TD + PW));
        if (exp_q.size() == 0) begin
          check(1'b0, "R5 unexpected write", out_bits, model);
        end else begin
          logic [127:0] e;
          e = exp_q.pop_front();
          check(out_bits == e, "R1 R2 R4 write result", out_bits, e);
        end
        blen = 0;
        done_cnt++;
      end
      busy_prev = busy;
    end
  end

  task automatic finish_run;
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 5);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    int t;
    repeat (5) @(negedge clk);
    check(out_bits == '0, "R9 outputs cleared", out_bits, '0);
    check(busy == 1'b0, "R9 busy low", 128'(busy), 128'(0));
    rst_n = 1'b1;
    quiet(mk(0, 0, 0), "R9 device 0 accepted at reset");

    wr(1, 0, 1);
    wr(2, 7, 1);
    wr(15, 7, 1);
    wr(0, 3, 1);
    wr(5, 4, 1);
    wr(1, 0, 0);
    wr(1 + 8, 2, 1);

    quiet(mk(9, 6, 1), "R3 R5 same device new position");
    quiet(mk(9, 1, 0), "R5 same device repeated");

    wr(2, 7, 1);
    check(out_bits == model, "R6 rewrite same value", out_bits, model);

    // one-cycle glitch on the device field
    begin
      int r0;
      r0 = rise_cnt;
      @(negedge clk); host_byte = mk(12, 1, 1);
      @(negedge clk); host_byte = mk(2, 7, 1);
      repeat (15) @(negedge clk);
      check(rise_cnt == r0, "R7 glitch ignored", 128'(rise_cnt), 128'(r0));
      check(out_bits == model, "R7 outputs kept", out_bits, model);
    end

    // change of input during a write
    t = done_cnt + 2;
    push_write(3, 2, 1);
    while (!busy) @(negedge clk);
    model[7*8 + 5] = 1'b1;
    exp_q.push_back(model);
    host_byte = mk(7, 5, 1);
    wait_done(t);
    check(out_bits[7*8 + 2] == 1'b0, "R8 capture kept during write", 128'(out_bits[7*8+2]), 128'(0));
    check(out_bits == model, "R8 pending selection written", out_bits, model);

    check(exp_q.size() == 0, "R4 all writes seen", 128'(exp_q.size()), 128'(0));
    finish_run();
  end
endmodule